// File: doc/BRIEF.md
# Audio Sample Clock Generator

This block produces the three clocks of a serial audio port from one system clock that runs at 768 times the sample rate. As clock master it divides the system clock down to an oversampling clock for converters (MCK), a bit clock and a left/right word clock. All three come from counters that restart together, so they keep a fixed phase to one another. It also emits one-cycle enables on the system clock. These mark bit-clock rising and falling edges and word-clock changes, so a serial data engine in the same clock domain can shift and latch without sampling the clocks itself.

As clock follower the block routes externally supplied bit and word clocks straight to its clock outputs and holds MCK low. The edge enables are then taken from a two-stage synchronizer on the external clocks. The follower/master choice, the MCK divisor and the bit-clock rate are sampled only at a frame boundary. At that boundary every divider starts again from zero.

Top module: `aclk_gen`

## Requirements
- R1: While `rstN` is low every output is 0. After release the first rising clock edge is a frame boundary that loads `slaveSel`, `mckDiv3Sel` and `bckSlowSel`; the cycle after it is frame position 0.
- R2: In master mode with `mckDiv3Sel`=0 active, `mckOut` is high at even frame positions and low at odd ones: system clock / 2, 50 % duty.
- R3: In master mode with `mckDiv3Sel`=1 active, `mckOut` is high at positions divisible by 3 and low for the two following cycles: system clock / 3, one cycle high and two low.
- R4: In master mode `bckOut` has period 12 cycles when `bckSlowSel`=0 (64 Fs) and 24 cycles when `bckSlowSel`=1 (32 Fs). It is low in the first half of each period, counted from frame position 0.
- R5: In master mode a frame is 768 cycles; `lrOut` is low for positions 0..383 and high for 384..767.
- R6: In master mode every change of `lrOut` falls in a cycle where `bckOut` falls, so each word-clock half holds 32 (64 Fs) or 16 (32 Fs) whole bit-clock periods.
- R7: In master mode `bckRiseEn` / `bckFallEn` are high for exactly the first cycle in which `bckOut` shows its new high / low level.
- R8: In master mode `lrEdgeEn` is high for exactly the first cycle in which `lrOut` shows a new level.
- R9: In slave mode `bckOut` equals `bckIn` and `lrOut` equals `lrIn` with no register in the path, and `mckOut` is held at 0.
- R10: In slave mode a level change on `bckIn` or `lrIn` that is sampled at rising edge k gives a one-cycle `bckRiseEn` / `bckFallEn` / `lrEdgeEn` in the cycle after edge k+1.
- R11: A change of any select input takes effect only at the frame boundary (position 767 to 0). Until then the previous mode continues unchanged, and at the boundary the MCK, bit-clock and word-clock dividers all restart at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 768 x sample rate |
| rstN | input | 1 | Asynchronous reset, active low |
| slaveSel | input | 1 | 1 = follow external clocks, 0 = generate clocks |
| mckDiv3Sel | input | 1 | 1 = MCK is clk/3, 0 = MCK is clk/2 |
| bckSlowSel | input | 1 | 1 = bit clock 32 Fs, 0 = bit clock 64 Fs |
| bckIn | input | 1 | External bit clock (slave mode) |
| lrIn | input | 1 | External word clock (slave mode) |
| mckOut | output | 1 | Converter oversampling clock |
| bckOut | output | 1 | Bit clock output |
| lrOut | output | 1 | Word clock output |
| bckRiseEn | output | 1 | One-cycle mark of a bit-clock rising edge |
| bckFallEn | output | 1 | One-cycle mark of a bit-clock falling edge |
| lrEdgeEn | output | 1 | One-cycle mark of a word-clock change |

## Verification
Two functions meet in the same cycle. In master mode a word-clock change must land in a cycle that also carries a bit-clock falling enable, and at a frame boundary a pending select change must take over in the same cycle. The bench asks for the change mid-frame. A reference model advances one frame position per clock and applies the request only on its own 767-to-0 wrap. Every output is then compared in every cycle, including the boundary cycle where the old and new bit-clock rates and MCK divisors meet. Wherever the model expects a word-clock edge, the bench also requires the falling-edge enable in that same cycle.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  // Strobes and active configuration passed from control to datapath.
  typedef struct packed {
    logic restart;   // last frame position: all dividers restart next edge
    logic lrNext;    // word-clock level for the next cycle
    logic slave;     // active mode: follow external clocks
    logic div3;      // active MCK divisor: 1 = divide by 3
    logic slow;      // active bit-clock rate: 1 = 32 Fs
  } ctl_t;

endpackage

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
  import aclk_pkg::*;
#(
  parameter int FRAME_LEN = 768
) (
  input  logic clk,
  input  logic rstN,
  input  logic slaveSel,
  input  logic mckDiv3Sel,
  input  logic bckSlowSel,
  output ctl_t ctl
);

  localparam int FW = $clog2(FRAME_LEN);
  localparam logic [FW-1:0] LAST_POS = FW'(FRAME_LEN - 1);
  localparam logic [FW-1:0] HALF_POS = FW'(FRAME_LEN / 2);

  logic [FW-1:0] frameCnt;
  logic [FW-1:0] frameNext;
  logic          atBoundary;
  logic          cfgSlave;
  logic          cfgDiv3;
  logic          cfgSlow;

  assign atBoundary = (frameCnt == LAST_POS);
  assign frameNext  = atBoundary ? '0 : frameCnt + FW'(1);

  // Reset parks the counter on the last position so the first edge after
  // release is a boundary that loads the select inputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= LAST_POS;
      cfgSlave <= 1'b0;
      cfgDiv3  <= 1'b0;
      cfgSlow  <= 1'b0;
    end else begin
      frameCnt <= frameNext;
      if (atBoundary) begin
        cfgSlave <= slaveSel;
        cfgDiv3  <= mckDiv3Sel;
        cfgSlow  <= bckSlowSel;
      end
    end
  end

  always_comb begin
    ctl.restart = atBoundary;
    ctl.lrNext  = (frameNext >= HALF_POS);
    ctl.slave   = cfgSlave;
    ctl.div3    = cfgDiv3;
    ctl.slow    = cfgSlow;
  end

endmodule

// File: rtl/aclk_datapath.sv
module aclk_datapath
  import aclk_pkg::*;
#(
  parameter int MCK_DIV_A    = 2,
  parameter int MCK_DIV_B    = 3,
  parameter int BCK_DIV_FAST = 12,
  parameter int BCK_DIV_SLOW = 24,
  parameter int SYNC_DEPTH   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  ctl_t ctl,
  input  logic bckIn,
  input  logic lrIn,
  output logic mckOut,
  output logic bckOut,
  output logic lrOut,
  output logic bckRiseEn,
  output logic bckFallEn,
  output logic lrEdgeEn
);

  localparam int MCK_MAX = (MCK_DIV_A > MCK_DIV_B) ? MCK_DIV_A : MCK_DIV_B;
  localparam int BCK_MAX = (BCK_DIV_FAST > BCK_DIV_SLOW) ? BCK_DIV_FAST : BCK_DIV_SLOW;
  localparam int MW = (MCK_MAX > 2) ? $clog2(MCK_MAX) : 1;
  localparam int BW = $clog2(BCK_MAX);
  localparam int NEXT = 2;  // external clocks: index 0 bit clock, 1 word clock

  // ---------------- generated clocks ----------------
  logic [MW-1:0] mckCnt, mckNext, mckLim;
  logic [BW-1:0] bckCnt, bckNext, bckLim, bckHalf;
  logic          mckGen, bckGen, lrGen;
  logic          bckGenD, lrGenD;

  always_comb begin
    mckLim  = ctl.div3 ? MW'(MCK_DIV_B - 1) : MW'(MCK_DIV_A - 1);
    bckLim  = ctl.slow ? BW'(BCK_DIV_SLOW - 1) : BW'(BCK_DIV_FAST - 1);
    bckHalf = ctl.slow ? BW'(BCK_DIV_SLOW / 2) : BW'(BCK_DIV_FAST / 2);
    if (ctl.restart || mckCnt == mckLim) mckNext = '0;
    else                                 mckNext = mckCnt + MW'(1);
    if (ctl.restart || bckCnt == bckLim) bckNext = '0;
    else                                 bckNext = bckCnt + BW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mckCnt  <= '0;
      bckCnt  <= '0;
      mckGen  <= 1'b0;
      bckGen  <= 1'b0;
      lrGen   <= 1'b0;
      bckGenD <= 1'b0;
      lrGenD  <= 1'b0;
    end else begin
      mckCnt  <= mckNext;
      bckCnt  <= bckNext;
      mckGen  <= (mckNext == '0);
      bckGen  <= (bckNext >= bckHalf);
      lrGen   <= ctl.lrNext;
      bckGenD <= bckGen;
      lrGenD  <= lrGen;
    end
  end

  // ---------------- external clock synchronizers ----------------
  logic [NEXT-1:0] extRaw, extNow, extOld;
  assign extRaw = {lrIn, bckIn};

  for (genvar g = 0; g < NEXT; g++) begin : g_sync
    logic [SYNC_DEPTH:0] shreg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shreg <= '0;
      else       shreg <= {shreg[SYNC_DEPTH-1:0], extRaw[g]};
    end
    assign extNow[g] = shreg[SYNC_DEPTH-1];
    assign extOld[g] = shreg[SYNC_DEPTH];
  end

  // ---------------- output selection ----------------
  always_comb begin
    if (ctl.slave) begin
      mckOut    = 1'b0;
      bckOut    = bckIn;
      lrOut     = lrIn;
      bckRiseEn = extNow[0] & ~extOld[0];
      bckFallEn = ~extNow[0] & extOld[0];
      lrEdgeEn  = extNow[1] ^ extOld[1];
    end else begin
      mckOut    = mckGen;
      bckOut    = bckGen;
      lrOut     = lrGen;
      bckRiseEn = bckGen & ~bckGenD;
      bckFallEn = ~bckGen & bckGenD;
      lrEdgeEn  = lrGen ^ lrGenD;
    end
  end

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int FRAME_LEN    = 768,
  parameter int MCK_DIV_A    = 2,
  parameter int MCK_DIV_B    = 3,
  parameter int BCK_DIV_FAST = 12,
  parameter int BCK_DIV_SLOW = 24,
  parameter int SYNC_DEPTH   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic slaveSel,
  input  logic mckDiv3Sel,
  input  logic bckSlowSel,
  input  logic bckIn,
  input  logic lrIn,
  output logic mckOut,
  output logic bckOut,
  output logic lrOut,
  output logic bckRiseEn,
  output logic bckFallEn,
  output logic lrEdgeEn
);

  ctl_t ctlBus;

  aclk_ctrl #(
    .FRAME_LEN (FRAME_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .slaveSel   (slaveSel),
    .mckDiv3Sel (mckDiv3Sel),
    .bckSlowSel (bckSlowSel),
    .ctl        (ctlBus)
  );

  aclk_datapath #(
    .MCK_DIV_A    (MCK_DIV_A),
    .MCK_DIV_B    (MCK_DIV_B),
    .BCK_DIV_FAST (BCK_DIV_FAST),
    .BCK_DIV_SLOW (BCK_DIV_SLOW),
    .SYNC_DEPTH   (SYNC_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlBus),
    .bckIn     (bckIn),
    .lrIn      (lrIn),
    .mckOut    (mckOut),
    .bckOut    (bckOut),
    .lrOut     (lrOut),
    .bckRiseEn (bckRiseEn),
    .bckFallEn (bckFallEn),
    .lrEdgeEn  (lrEdgeEn)
  );

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
  input logic clk,
  input logic rstN,
  input logic ctlSlave,
  input logic ctlDiv3,
  input logic mckOut,
  input logic lrOut,
  input logic bckRiseEn,
  input logic bckFallEn,
  input logic lrEdgeEn
);

  // R2: a divide-by-2 MCK high cycle is followed by a low cycle
  p_mck_half_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlSlave && !ctlDiv3 && mckOut) |=> !mckOut);

  // R3: a divide-by-3 MCK high cycle is followed by two low cycles
  p_mck_third_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlSlave && ctlDiv3 && mckOut) |=> !mckOut ##1 !mckOut);

  // R6: word-clock changes only together with a bit-clock fall
  p_lr_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlSlave && lrEdgeEn) |-> bckFallEn);

  // R7: rise and fall marks never coincide
  p_edge_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bckRiseEn, bckFallEn}));

  // R11: every generated frame starts with MCK high (dividers restarted)
  p_frame_mck_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlSlave && !$past(ctlSlave) && $fell(lrOut)) |-> mckOut);

endmodule

bind aclk_gen aclk_gen_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctlSlave  (ctlBus.slave),
  .ctlDiv3   (ctlBus.div3),
  .mckOut    (mckOut),
  .lrOut     (lrOut),
  .bckRiseEn (bckRiseEn),
  .bckFallEn (bckFallEn),
  .lrEdgeEn  (lrEdgeEn)
);

// File: tb/aclk_gen_tb.sv
module aclk_gen_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveSel = 1'b0;
  logic mckDiv3Sel = 1'b0;
  logic bckSlowSel = 1'b0;
  logic bckIn = 1'b0;
  logic lrIn = 1'b0;
  logic mckOut, bckOut, lrOut, bckRiseEn, bckFallEn, lrEdgeEn;

  always #5 clk = ~clk;

  aclk_gen u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .slaveSel   (slaveSel),
    .mckDiv3Sel (mckDiv3Sel),
    .bckSlowSel (bckSlowSel),
    .bckIn      (bckIn),
    .lrIn       (lrIn),
    .mckOut     (mckOut),
    .bckOut     (bckOut),
    .lrOut      (lrOut),
    .bckRiseEn  (bckRiseEn),
    .bckFallEn  (bckFallEn),
    .lrEdgeEn   (lrEdgeEn)
  );

  typedef struct {
    bit inRst;
    bit slv;
    bit pend;
    bit div3;
    bit mck, bck, lr, rise, fall, lre;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int mFrame = 767;
  bit mSlave = 0, mDiv3 = 0, mSlow = 0;
  bit s1 = 0, s2 = 0, s3 = 0, l1 = 0, l2 = 0, l3 = 0;
  bit prevB = 0, prevL = 0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver side: the model advances per edge and pushes the expected outputs.
  always @(posedge clk) begin
    exp_t e;
    int per, mdiv;
    bit gm, gb, gl;
    e = '{default: 0};
    if (!rstN) begin
      mFrame = 767; mSlave = 0; mDiv3 = 0; mSlow = 0;
      s1 = 0; s2 = 0; s3 = 0; l1 = 0; l2 = 0; l3 = 0;
      prevB = 0; prevL = 0;
      e.inRst = 1;
    end else begin
      s3 = s2; s2 = s1; s1 = bckIn;
      l3 = l2; l2 = l1; l1 = lrIn;
      if (mFrame == 767) begin
        mFrame = 0; mSlave = slaveSel; mDiv3 = mckDiv3Sel; mSlow = bckSlowSel;
      end else begin
        mFrame++;
      end
      mdiv = mDiv3 ? 3 : 2;
      per  = mSlow ? 24 : 12;
      gm = (mFrame % mdiv) == 0;
      gb = (mFrame % per) >= per / 2;
      gl = mFrame >= 384;
      e.slv  = mSlave;
      e.div3 = mDiv3;
      e.pend = (slaveSel != mSlave) || (mckDiv3Sel != mDiv3) || (bckSlowSel != mSlow);
      if (mSlave) begin
        e.rise = s2 & ~s3;
        e.fall = ~s2 & s3;
        e.lre  = l2 ^ l3;
      end else begin
        e.mck  = gm;
        e.bck  = gb;
        e.lr   = gl;
        e.rise = gb & ~prevB;
        e.fall = ~gb & prevB;
        e.lre  = gl ^ prevL;
      end
      prevB = gb;
      prevL = gl;
    end
    expQ.push_back(e);
  end

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (expQ.size() > 0 && !finished) begin
      e = expQ.pop_front();
      if (e.inRst) begin
        chk("R1", "mckOut", mckOut, 1'b0);
        chk("R1", "bckOut", bckOut, 1'b0);
        chk("R1", "lrOut", lrOut, 1'b0);
        chk("R1", "bckRiseEn", bckRiseEn, 1'b0);
        chk("R1", "bckFallEn", bckFallEn, 1'b0);
        chk("R1", "lrEdgeEn", lrEdgeEn, 1'b0);
      end else if (e.slv) begin
        chk("R9", "mckOut", mckOut, 1'b0);
        chk("R9", "bckOut", bckOut, bckIn);
        chk("R9", "lrOut", lrOut, lrIn);
        chk("R10", "bckRiseEn", bckRiseEn, e.rise);
        chk("R10", "bckFallEn", bckFallEn, e.fall);
        chk("R10", "lrEdgeEn", lrEdgeEn, e.lre);
      end else begin
        chk(e.pend ? "R11" : (e.div3 ? "R3" : "R2"), "mckOut", mckOut, e.mck);
        chk(e.pend ? "R11" : "R4", "bckOut", bckOut, e.bck);
        chk("R5", "lrOut", lrOut, e.lr);
        chk("R7", "bckRiseEn", bckRiseEn, e.rise);
        chk("R7", "bckFallEn", bckFallEn, e.fall);
        chk("R8", "lrEdgeEn", lrEdgeEn, e.lre);
        if (e.lre) chk("R6", "bckFallEn with word-clock edge", bckFallEn, 1'b1);
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic ext_clocks(input int cycles, input int bHalf, input int lHalf);
    for (int c = 0; c < cycles; c++) begin
      wait_cycles(1);
      if (c % bHalf == 0) bckIn = ~bckIn;
      if (c % lHalf == 0) lrIn = ~lrIn;
    end
  endtask

  task automatic finish_run;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait_cycles(4);
    rstN = 1'b1;                  // R1: first edge after release is a boundary
    wait_cycles(1600);            // master, clk/2, 64 Fs
    mckDiv3Sel = 1'b1;            // R11: mid-frame request, R3 after boundary
    wait_cycles(1600);
    bckSlowSel = 1'b1;            // R11 then R4 at 32 Fs
    wait_cycles(1600);
    slaveSel = 1'b1;              // R9, R10 after boundary
    ext_clocks(2000, 5, 160);
    slaveSel = 1'b0;              // back to master; external clocks ignored
    mckDiv3Sel = 1'b0;
    bckSlowSel = 1'b0;
    ext_clocks(1700, 7, 100);
    wait_cycles(2);
    if (!finished) finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

endmodule